// File: doc/BRIEF.md
# Square-Root Band Address Encoder for a Multiplexed DRAM Bus

This block turns a binary address of 2N bits into a row half and a column half. It then drives the two halves, one after the other, on an N-bit time-multiplexed DRAM address bus. The mapping is built so that, when addresses arrive in counting order, the column half of each address equals the row half of the next one. The bus lines therefore do not switch between the end of one address and the start of the next. The order it follows is an Eulerian cycle over the complete row/column graph, not plain binary order.

The mapping splits an address x into a band index k and an offset q. The band index is the integer square root of x, taken from a parallel bank of comparators against constant squares. The offset is x minus k squared. The offset then chooses between a row-k cell, a column-k cell, or the closing cell of the band.

Two control flags adjust the mapping:
- A descending flag exchanges the two halves, which keeps the zero-switch property for addresses that count down.
- A word-align flag rotates the address right by two bits first, so that consecutive 4-byte-aligned addresses become consecutive integers.

Top module: `sqband_addr_encoder`

## Requirements
- R1: During and right after reset, bus_addr is 0, row_stb and col_stb are 0, and in_ready is 1.
- R2: The band index k is floor(sqrt(x)) and the offset is q = x - k*k, so 0 <= q <= 2k. When q is odd, the row is k and the column is (q+1)/2.
- R3: When q is even and q/2 equals k, the row is k and the column is 0. This is the closing cell of the band.
- R4: When q is even and q/2 differs from k, the row is q/2 and the column is k.
- R5: With N=2, inputs 0 to 15 give the row/column codes 0000, 0001, 0101, 0100, 0010, 1001, 0110, 1010, 1000, 0011, 1101, 0111, 1110, 1011, 1111, 1100. The row bits are the upper two bits of each code.
- R6: For every x, the column of x equals the row of (x+1) mod 2^(2N), and all 2^(2N) row/column pairs are distinct.
- R7: With in_desc=1, the row and column produced for an address are exchanged.
- R8: With in_wordalign=1, the address is first rotated right by two bits, as {a[1:0], a[2N-1:2]}, and then encoded.
- R9: Suppose an address is accepted at a rising edge. After that edge, bus_addr carries the row and row_stb is 1. After the next edge, bus_addr carries the column and col_stb is 1. The two strobes are never high together.
- R10: in_ready is 0 while the column phase is pending, and in_valid is ignored at that time. While no address is being sent, both strobes are 0 and bus_addr keeps the last column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Address present on in_addr |
| in_addr | input | 2N | Binary address to encode |
| in_desc | input | 1 | Descending access: exchange row and column |
| in_wordalign | input | 1 | Rotate the address right by two bits before encoding |
| in_ready | output | 1 | High when a new address can be taken |
| bus_addr | output | N | Multiplexed row/column bus |
| row_stb | output | 1 | bus_addr carries a row half |
| col_stb | output | 1 | bus_addr carries a column half |

## Verification
The bench runs the full ascending sweep on two instances: a small one (N=2) and a wider one (N=4).

On the small instance, the exact code sequence is checked. This pins down where each band starts and the swap order inside it. On the wider instance, every pair is compared against a square root that is found by searching. Each pair is also checked for adjacency with its successor, including the wrap from the last address to 0, and for being distinct from all the others. A mapping that only looks right on a 2-bit bus fails these checks.

Three smaller runs complete the coverage:
- A descending run separates the exchange path from the plain path.
- Rotated inputs with non-zero low bits separate a rotation from a plain shift.
- Holding in_valid high through the column phase shows whether the sequencer takes an address too early.

// File: rtl/sqband_pkg.sv
package sqband_pkg;

  typedef enum logic {
    PH_ROW = 1'b0,
    PH_COL = 1'b1
  } phase_e;

  localparam int unsigned ROT_BITS = 2;

endpackage

// File: rtl/sqband_isqrt_lut.sv
module sqband_isqrt_lut #(
  parameter int unsigned N = 4
) (
  input  logic [2*N-1:0] x,
  output logic [N-1:0]   k
);
  localparam int unsigned AW   = 2 * N;
  localparam int unsigned MAXK = (1 << N) - 1;

  logic [MAXK-1:0] ge_sq;

  for (genvar m = 1; m <= MAXK; m++) begin : g_cmp
    localparam logic [AW-1:0] SQ = AW'(m * m);
    assign ge_sq[m-1] = (x >= SQ);
  end

  assign k = N'($countones(ge_sq));

  logic [AW:0] k_sq, k1_sq;
  always_comb begin
    k_sq  = (AW+1)'(k) * (AW+1)'(k);
    k1_sq = ((AW+1)'(k) + 1'b1) * ((AW+1)'(k) + 1'b1);
    p_sqrt_floor_r2: assert (k_sq <= (AW+1)'(x) && k1_sq > (AW+1)'(x));
  end
endmodule

// File: rtl/sqband_band_map.sv
module sqband_band_map #(
  parameter int unsigned N = 4
) (
  input  logic [2*N-1:0] x,
  input  logic [N-1:0]   k,
  output logic [N-1:0]   row,
  output logic [N-1:0]   col
);
  localparam int unsigned AW = 2 * N;

  function automatic logic [AW-1:0] band_base(input logic [N-1:0] kk);
    return {{N{1'b0}}, kk} * {{N{1'b0}}, kk};
  endfunction

  function automatic logic [N-1:0] half_up(input logic [N:0] qq);
    return qq[N:1] + {{(N-1){1'b0}}, qq[0]};
  endfunction

  logic [AW-1:0] q_full;
  logic [N:0]    q;
  logic [N-1:0]  j;
  logic          q_odd;
  logic          band_close;

  assign q_full     = x - band_base(k);
  assign q          = q_full[N:0];
  assign q_odd      = q[0];
  assign j          = half_up(q);
  assign band_close = !q_odd && (j == k);

  always_comb begin
    if (q_odd) begin
      row = k;
      col = j;
    end else if (band_close) begin
      row = k;
      col = '0;
    end else begin
      row = j;
      col = k;
    end
  end

  always_comb begin
    p_offset_in_band_r2: assert (q_full <= {{(N-1){1'b0}}, k, 1'b0});
    p_half_le_band_r4:   assert (j <= k);
  end
endmodule

// File: rtl/sqband_bus_phaser.sv
module sqband_bus_phaser
  import sqband_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take_valid,
  input  logic [N-1:0] row_in,
  input  logic [N-1:0] col_in,
  output logic         ready,
  output logic [N-1:0] bus,
  output logic         row_stb,
  output logic         col_stb
);
  phase_e       ph;
  logic [N-1:0] col_hold;
  logic         accept;

  assign ready  = (ph == PH_ROW);
  assign accept = ready && take_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= PH_ROW;
      bus      <= '0;
      col_hold <= '0;
      row_stb  <= 1'b0;
      col_stb  <= 1'b0;
    end else begin
      case (ph)
        PH_ROW: begin
          col_stb <= 1'b0;
          if (accept) begin
            bus      <= row_in;
            col_hold <= col_in;
            row_stb  <= 1'b1;
            ph       <= PH_COL;
          end else begin
            row_stb <= 1'b0;
          end
        end
        default: begin
          bus     <= col_hold;
          row_stb <= 1'b0;
          col_stb <= 1'b1;
          ph      <= PH_ROW;
        end
      endcase
    end
  end

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(row_stb && col_stb));
  p_col_after_row_r9: assert property (@(posedge clk) disable iff (!rst_n)
    row_stb |=> col_stb);
  p_busy_in_row_r10: assert property (@(posedge clk) disable iff (!rst_n)
    row_stb |-> !ready);
  p_no_take_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> !row_stb);
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!row_stb && !col_stb) |-> $stable(bus));
endmodule

// File: rtl/sqband_addr_encoder.sv
module sqband_addr_encoder
  import sqband_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [2*N-1:0] in_addr,
  input  logic           in_desc,
  input  logic           in_wordalign,
  output logic           in_ready,
  output logic [N-1:0]   bus_addr,
  output logic           row_stb,
  output logic           col_stb
);
  localparam int unsigned AW = 2 * N;

  function automatic logic [AW-1:0] rot_right(input logic [AW-1:0] a);
    return {a[ROT_BITS-1:0], a[AW-1:ROT_BITS]};
  endfunction

  logic [AW-1:0] x_eff;
  logic [N-1:0]  band_k;
  logic [N-1:0]  map_row, map_col;
  logic [N-1:0]  send_row, send_col;

  assign x_eff = in_wordalign ? rot_right(in_addr) : in_addr;

  sqband_isqrt_lut #(.N(N)) u_sqrt (
    .x (x_eff),
    .k (band_k)
  );

  sqband_band_map #(.N(N)) u_map (
    .x   (x_eff),
    .k   (band_k),
    .row (map_row),
    .col (map_col)
  );

  assign send_row = in_desc ? map_col : map_row;
  assign send_col = in_desc ? map_row : map_col;

  sqband_bus_phaser #(.N(N)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_valid (in_valid),
    .row_in     (send_row),
    .col_in     (send_col),
    .ready      (in_ready),
    .bus        (bus_addr),
    .row_stb    (row_stb),
    .col_stb    (col_stb)
  );
endmodule

// File: tb/sim_sqband_addr_encoder.sv
module sim_sqband_addr_encoder;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, vld, desc, walign;
  logic [7:0] addr;
  logic       rdy0, rs0, cs0, rdy1, rs1, cs1;
  logic [1:0] bus0;
  logic [3:0] bus1;

  sqband_addr_encoder #(.N(2)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_addr(addr[3:0]),
    .in_desc(desc), .in_wordalign(walign), .in_ready(rdy0),
    .bus_addr(bus0), .row_stb(rs0), .col_stb(cs0));

  sqband_addr_encoder #(.N(4)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(vld), .in_addr(addr),
    .in_desc(desc), .in_wordalign(walign), .in_ready(rdy1),
    .bus_addr(bus1), .row_stb(rs1), .col_stb(cs1));

  localparam logic [3:0] EXP2 [16] = '{
    4'b0000, 4'b0001, 4'b0101, 4'b0100, 4'b0010, 4'b1001, 4'b0110, 4'b1010,
    4'b1000, 4'b0011, 4'b1101, 4'b0111, 4'b1110, 4'b1011, 4'b1111, 4'b1100};

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [1:0] r0, c0;
  logic [3:0] r1, c1;
  logic [3:0] row_of [256];
  logic [3:0] col_of [256];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference written from the requirement text: search for the square root
  task automatic ref_enc(input int x, output int row, output int col, output string req);
    int k, q;
    k = 0;
    while ((k + 1) * (k + 1) <= x) k++;
    q = x - k * k;
    if (q % 2 == 1) begin
      row = k; col = (q + 1) / 2; req = "R2";
    end else if (q / 2 == k) begin
      row = k; col = 0; req = "R3";
    end else begin
      row = q / 2; col = k; req = "R4";
    end
  endtask

  // accepts one address and samples both halves on both instances (R9)
  task automatic send(input logic [7:0] a, input bit d, input bit w);
    vld = 1'b1; addr = a; desc = d; walign = w;
    @(posedge clk); @(negedge clk);
    vld = 1'b0;
    chk(rs1 && !cs1 && !rdy1 && rs0, "R9 row phase", {rs1, cs1, rdy1}, 3'b100);
    r0 = bus0; r1 = bus1;
    @(posedge clk); @(negedge clk);
    chk(cs1 && !rs1 && rdy1 && cs0, "R9 col phase", {rs1, cs1, rdy1}, 3'b011);
    c0 = bus0; c1 = bus1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int er, ec;
    string rq;
    bit seen [256];
    rst_n = 1'b0; vld = 1'b0; addr = '0; desc = 1'b0; walign = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(bus1 == 0 && !rs1 && !cs1 && rdy1 && bus0 == 0, "R1 in reset",
        {bus1, rs1, cs1, rdy1}, 1);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(bus1 == 0 && !rs1 && !cs1 && rdy1, "R1 after reset",
        {bus1, rs1, cs1, rdy1}, 1);

    // table-driven ascending sweep
    for (int x = 0; x < 256; x++) begin
      send(8'(x), 1'b0, 1'b0);
      row_of[x] = r1; col_of[x] = c1;
      if (x < 16) chk({r0, c0} == EXP2[x], "R5 code", {r0, c0}, EXP2[x]);
      ref_enc(x, er, ec, rq);
      chk(r1 == 4'(er) && c1 == 4'(ec), rq, {r1, c1}, {4'(er), 4'(ec)});
    end

    // R6 adjacency and distinct pairs
    for (int x = 0; x < 256; x++) seen[x] = 1'b0;
    for (int x = 0; x < 256; x++) begin
      chk(col_of[x] == row_of[(x + 1) % 256], "R6 adjacency",
          col_of[x], row_of[(x + 1) % 256]);
      chk(!seen[{row_of[x], col_of[x]}], "R6 distinct", {row_of[x], col_of[x]}, -1);
      seen[{row_of[x], col_of[x]}] = 1'b1;
    end

    // R7 descending exchange
    for (int x = 255; x >= 240; x--) begin
      send(8'(x), 1'b1, 1'b0);
      chk(r1 == col_of[x] && c1 == row_of[x], "R7 swap", {r1, c1}, {col_of[x], row_of[x]});
      if (x < 256) chk({c0, r0} == EXP2[x % 16], "R7 swap n2", {c0, r0}, EXP2[x % 16]);
    end

    // R8 word-align rotate right by two
    foreach (EXP2[i]) begin
      logic [7:0] a, rot;
      a = 8'(i * 37 + 3);
      rot = {a[1:0], a[7:2]};
      send(a, 1'b0, 1'b1);
      chk(r1 == row_of[rot] && c1 == col_of[rot], "R8 rotate", {r1, c1},
          {row_of[rot], col_of[rot]});
    end

    // R10 in_valid held through the column phase is ignored
    vld = 1'b1; addr = 8'd77; desc = 1'b0; walign = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(!rdy1 && bus1 == row_of[77], "R10 busy row", {rdy1, bus1}, {1'b0, row_of[77]});
    addr = 8'd200;
    @(posedge clk); @(negedge clk);
    chk(cs1 && bus1 == col_of[77], "R10 col kept", bus1, col_of[77]);
    vld = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(!rs1 && !cs1 && bus1 == col_of[77], "R10 idle hold",
        {rs1, cs1, bus1}, {2'b00, col_of[77]});
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!rs1 && !cs1 && bus1 == col_of[77] && rdy1, "R10 idle stable",
        {rs1, cs1, bus1}, {2'b00, col_of[77]});

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule